// File: doc/BRIEF.md
# Splitter Board I/O Port Decoder

This block sits between an 8-bit ISA-style I/O bus and the register file of a small video splitter board. The board has three palette register groups: a secondary group and two auxiliary groups. Each group has four byte-wide registers. The block decodes an I/O window that starts at 0x300 and ends at 0x31A. For each group it produces a select pulse and a 2-bit register offset. It passes the write byte through to the groups, and on a read it returns the byte that the addressed group reads back. It also holds a single high-colour divider enable bit. Writing to either of two strobe addresses changes that bit, and the data byte has no effect on it.

The bus strobes are level signals that can stay asserted for many clock cycles. An access state machine turns each strobe assertion into exactly one pulse cycle, so that a downstream address counter with auto-increment advances once per access. Its states are IDLE, WR_PULSE, WR_HOLD, RD_PULSE and RD_HOLD. The transitions are:
- IDLE to WR_PULSE when the write strobe is high, which takes priority.
- IDLE to RD_PULSE when only the read strobe is high.
- Each pulse state to its hold state unconditionally.
- Each hold state back to IDLE once both strobes are low.

The address and data are captured on the edge that leaves IDLE.

Top module: `splitter_io_decoder`

## Requirements
- R1: After reset the divider enable is 0, no group select is active, `rd_claim` is 0 and `rdata` is 0xFF.
- R2: A write to group g pulses bit g of `grp_sel` (bit 0 secondary at 0x302..0x305, bit 1 aux1 at 0x30A..0x30D, bit 2 aux2 at 0x312..0x315). The pulse is high in the cycle after the edge that samples the strobe, with `grp_write` high and `wdata` equal to the written byte.
- R3: `reg_off` is the address minus the group's first address: 0 pixel mask, 1 read address, 2 write address, 3 data.
- R4: A select is high for exactly one cycle per access, however long the strobe is held. A new access starts only after both strobes have been low at a clock edge.
- R5: A write to 0x319 clears the divider enable one cycle after the pulse cycle, whatever the data.
- R6: A write to 0x31A sets the divider enable one cycle after the pulse cycle, whatever the data.
- R7: A read from a group pulses that group's select with `grp_write` low. From the pulse cycle until the strobe is released, `rd_claim` is 1 and `rdata` equals that group's read-back byte, taken from bits [8g+7:8g] of `rb_data`.
- R8: An address inside the window that hits no group and no strobe selects nothing and leaves the divider unchanged on write. On read it returns 0xFF with `rd_claim` high.
- R9: An address outside 0x300..0x31A selects nothing, never raises `rd_claim` (rdata stays 0xFF), and leaves the divider unchanged.
- R10: If both strobes are high at the same edge in IDLE, the access is a write. The read is ignored: `grp_write` is high and `rd_claim` stays 0.
- R11: Reads of 0x319 and 0x31A leave the divider unchanged and return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Board clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 10 | I/O address |
| io_din | input | 8 | Write data from the bus |
| io_rd | input | 1 | Read strobe, active high |
| io_wr | input | 1 | Write strobe, active high |
| rb_data | input | 24 | Read-back bytes, group g in bits [8g+7:8g] |
| grp_sel | output | 3 | One-cycle select pulse per group |
| grp_write | output | 1 | High when the current pulse is a write |
| reg_off | output | 2 | Register offset within the group |
| wdata | output | 8 | Captured write byte |
| rdata | output | 8 | Read data returned to the bus |
| rd_claim | output | 1 | The window claims the current read |
| hc_div_en | output | 1 | High-colour divider enable |

## Verification
Two functions can collide in the same cycle. The first is the read and write paths, when both strobes rise together. The bench drives this deliberately at group, hole and strobe addresses. It judges the outcome by a write-type pulse, by `rd_claim` staying low, and by the divider following the write. The second is a held strobe overlapping the next access. Random hold lengths combined with back-to-back accesses show that only one pulse appears and that the divider changes only on the write pulse.

// File: rtl/spl_dec_pkg.sv
package spl_dec_pkg;
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WR_PULSE = 3'd1,
        ST_WR_HOLD  = 3'd2,
        ST_RD_PULSE = 3'd3,
        ST_RD_HOLD  = 3'd4
    } acc_state_t;

    localparam int unsigned BYTE_W = 8;
    localparam logic [BYTE_W-1:0] IDLE_BYTE = 8'hFF;
endpackage

// File: rtl/spl_addr_decode.sv
module spl_addr_decode #(
    parameter int unsigned ADDR_W   = 10,
    parameter int unsigned BASE     = 'h300,
    parameter int unsigned LAST_OFF = 'h1A,
    parameter int unsigned GRP_N    = 3,
    parameter int unsigned STRIDE   = 8,
    parameter int unsigned FIRST    = 2,
    parameter int unsigned CLR_OFF  = 'h19,
    parameter int unsigned SET_OFF  = 'h1A
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              in_win,
    output logic [GRP_N-1:0]  grp_hit,
    output logic [1:0]        off_sel,
    output logic              clr_hit,
    output logic              set_hit
);
    localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(BASE + LAST_OFF);
    localparam logic [ADDR_W-1:0] CLR_A  = ADDR_W'(CLR_OFF);
    localparam logic [ADDR_W-1:0] SET_A  = ADDR_W'(SET_OFF);

    logic [ADDR_W-1:0] rel;
    logic [1:0]        off_g [GRP_N];

    assign in_win  = (addr >= BASE_A) && (addr <= LAST_A);
    assign rel     = addr - BASE_A;
    assign clr_hit = in_win && (rel == CLR_A);
    assign set_hit = in_win && (rel == SET_A);

    for (genvar g = 0; g < GRP_N; g++) begin : g_grp
        localparam logic [ADDR_W-1:0] LO = ADDR_W'(g * STRIDE + FIRST);
        localparam logic [ADDR_W-1:0] HI = ADDR_W'(g * STRIDE + FIRST + 3);
        logic [ADDR_W-1:0] delta;
        assign delta      = rel - LO;
        assign grp_hit[g] = in_win && (rel >= LO) && (rel <= HI);
        assign off_g[g]   = grp_hit[g] ? delta[1:0] : 2'b00;
    end

    always_comb begin
        off_sel = 2'b00;
        for (int g = 0; g < GRP_N; g++) begin
            off_sel = off_sel | off_g[g];
        end
    end

    // R2
    always_comb begin
        grp_hit_onehot_chk: assert ($onehot0(grp_hit) || $isunknown(addr))
            else $error("group decode overlaps");
    end
endmodule

// File: rtl/spl_access_fsm.sv
module spl_access_fsm
    import spl_dec_pkg::*;
#(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_rd,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [BYTE_W-1:0] io_din,
    output logic              wr_pulse,
    output logic              rd_pulse,
    output logic              rd_active,
    output logic [ADDR_W-1:0] addr_q,
    output logic [BYTE_W-1:0] data_q
);
    acc_state_t state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (io_wr)      state_nx = ST_WR_PULSE;
                else if (io_rd) state_nx = ST_RD_PULSE;
            end
            ST_WR_PULSE: state_nx = ST_WR_HOLD;
            ST_RD_PULSE: state_nx = ST_RD_HOLD;
            ST_WR_HOLD, ST_RD_HOLD: begin
                if (!io_wr && !io_rd) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && (io_wr || io_rd)) begin
                addr_q <= io_addr;
                data_q <= io_din;
            end
        end
    end

    always_comb begin
        wr_pulse  = 1'b0;
        rd_pulse  = 1'b0;
        rd_active = 1'b0;
        unique case (state)
            ST_WR_PULSE: wr_pulse = 1'b1;
            ST_RD_PULSE: begin
                rd_pulse  = 1'b1;
                rd_active = 1'b1;
            end
            ST_RD_HOLD:  rd_active = 1'b1;
            default: ;
        endcase
    end

    // R4
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse || rd_pulse) |=> !(wr_pulse || rd_pulse))
        else $error("pulse longer than one cycle");

    // R10
    wr_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && io_wr && io_rd) |=> (wr_pulse && !rd_active))
        else $error("read won over write");
endmodule

// File: rtl/spl_div_ctrl.sv
module spl_div_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_pulse,
    input  logic set_hit,
    input  logic clr_hit,
    output logic div_en
);
    always_ff @(posedge clk) begin
        if (!rst_n)                    div_en <= 1'b0;
        else if (wr_pulse && set_hit)  div_en <= 1'b1;
        else if (wr_pulse && clr_hit)  div_en <= 1'b0;
    end

    // R6
    div_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && set_hit) |=> div_en)
        else $error("divider not set");

    // R5
    div_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && clr_hit) |=> !div_en)
        else $error("divider not cleared");

    // R8
    div_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_pulse && (set_hit || clr_hit)) |=> $stable(div_en))
        else $error("divider moved without strobe write");
endmodule

// File: rtl/spl_rdata_mux.sv
module spl_rdata_mux
    import spl_dec_pkg::*;
#(
    parameter int unsigned GRP_N = 3
) (
    input  logic                    claim,
    input  logic [GRP_N-1:0]        grp_hit,
    input  logic [GRP_N*BYTE_W-1:0] rb_data,
    output logic [BYTE_W-1:0]       rdata
);
    always_comb begin
        rdata = IDLE_BYTE;
        if (claim) begin
            for (int g = 0; g < GRP_N; g++) begin
                if (grp_hit[g]) rdata = rb_data[g*BYTE_W +: BYTE_W];
            end
        end
    end
endmodule

// File: rtl/splitter_io_decoder.sv
module splitter_io_decoder
    import spl_dec_pkg::*;
#(
    parameter int unsigned ADDR_W   = 10,
    parameter int unsigned BASE     = 'h300,
    parameter int unsigned LAST_OFF = 'h1A,
    parameter int unsigned GRP_N    = 3,
    parameter int unsigned STRIDE   = 8,
    parameter int unsigned FIRST    = 2,
    parameter int unsigned CLR_OFF  = 'h19,
    parameter int unsigned SET_OFF  = 'h1A
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       io_addr,
    input  logic [7:0]              io_din,
    input  logic                    io_rd,
    input  logic                    io_wr,
    input  logic [GRP_N*8-1:0]      rb_data,
    output logic [GRP_N-1:0]        grp_sel,
    output logic                    grp_write,
    output logic [1:0]              reg_off,
    output logic [7:0]              wdata,
    output logic [7:0]              rdata,
    output logic                    rd_claim,
    output logic                    hc_div_en
);
    logic              wr_pulse, rd_pulse, rd_active;
    logic [ADDR_W-1:0] addr_q;
    logic              in_win, clr_hit, set_hit;
    logic [GRP_N-1:0]  grp_hit;

    spl_access_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .io_rd(io_rd), .io_wr(io_wr),
        .io_addr(io_addr), .io_din(io_din),
        .wr_pulse(wr_pulse), .rd_pulse(rd_pulse), .rd_active(rd_active),
        .addr_q(addr_q), .data_q(wdata)
    );

    spl_addr_decode #(
        .ADDR_W(ADDR_W), .BASE(BASE), .LAST_OFF(LAST_OFF), .GRP_N(GRP_N),
        .STRIDE(STRIDE), .FIRST(FIRST), .CLR_OFF(CLR_OFF), .SET_OFF(SET_OFF)
    ) u_dec (
        .addr(addr_q), .in_win(in_win), .grp_hit(grp_hit), .off_sel(reg_off),
        .clr_hit(clr_hit), .set_hit(set_hit)
    );

    spl_div_ctrl u_div (
        .clk(clk), .rst_n(rst_n), .wr_pulse(wr_pulse),
        .set_hit(set_hit), .clr_hit(clr_hit), .div_en(hc_div_en)
    );

    assign rd_claim  = rd_active && in_win;
    assign grp_write = wr_pulse;
    assign grp_sel   = (wr_pulse || rd_pulse) ? grp_hit : '0;

    spl_rdata_mux #(.GRP_N(GRP_N)) u_mux (
        .claim(rd_claim), .grp_hit(grp_hit), .rb_data(rb_data), .rdata(rdata)
    );

    // R2
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grp_sel))
        else $error("more than one group selected");

    // R9
    no_claim_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_claim |-> (rdata == IDLE_BYTE))
        else $error("rdata driven without claim");

    // R10
    claim_not_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grp_write |-> !rd_claim)
        else $error("read claimed during write");
endmodule

// File: tb/splitter_io_decoder_test.sv
module splitter_io_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [9:0]  io_addr = '0;
    logic [7:0]  io_din = '0;
    logic        io_rd = 1'b0, io_wr = 1'b0;
    logic [23:0] rb_data = '0;
    logic [2:0]  grp_sel;
    logic        grp_write, rd_claim, hc_div_en;
    logic [1:0]  reg_off;
    logic [7:0]  wdata, rdata;

    int checks = 0, fails = 0, cycles = 0;
    bit exp_div = 1'b0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    splitter_io_decoder uut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_din(io_din),
        .io_rd(io_rd), .io_wr(io_wr), .rb_data(rb_data),
        .grp_sel(grp_sel), .grp_write(grp_write), .reg_off(reg_off),
        .wdata(wdata), .rdata(rdata), .rd_claim(rd_claim), .hc_div_en(hc_div_en)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int grp_of(input logic [9:0] a);
        for (int g = 0; g < 3; g++)
            if (a >= 10'h302 + g*8 && a <= 10'h305 + g*8) return g;
        return -1;
    endfunction

    function automatic bit in_window(input logic [9:0] a);
        return a >= 10'h300 && a <= 10'h31A;
    endfunction

    task automatic access(input logic [9:0] a, input logic [7:0] d,
                          input bit wr, input bit rd, input int hold);
        int  g;
        bit  is_rd_only;
        logic [2:0] exp_sel;
        logic [7:0] exp_rd;
        g = grp_of(a);
        is_rd_only = rd && !wr;
        exp_sel = (g >= 0) ? 3'(1 << g) : 3'b000;
        exp_rd = (is_rd_only && g >= 0) ? rb_data[g*8 +: 8] : 8'hFF;
        @(negedge clk);
        io_addr = a; io_din = d; io_wr = wr; io_rd = rd;
        @(negedge clk);
        // pulse cycle
        check(grp_sel == exp_sel, "R2/R7/R8/R9 select", grp_sel, exp_sel);
        check(grp_write == wr, "R10 grp_write", grp_write, wr);
        if (g >= 0) begin
            check(reg_off == 2'(a - (10'h302 + g*8)), "R3 offset", reg_off, 2'(a - (10'h302 + g*8)));
            if (wr) check(wdata == d, "R2 wdata", wdata, d);
        end
        check(rd_claim == (is_rd_only && in_window(a)), "R7/R9/R10 rd_claim",
              rd_claim, is_rd_only && in_window(a));
        check(rdata == exp_rd, "R7/R8/R11 rdata", rdata, exp_rd);
        if (wr && a == 10'h319) exp_div = 1'b0;
        if (wr && a == 10'h31A) exp_div = 1'b1;
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            check(grp_sel == 3'b000, "R4 no repeat pulse", grp_sel, 0);
            check(hc_div_en == exp_div, "R5/R6/R8/R11 divider", hc_div_en, exp_div);
            if (is_rd_only) check(rdata == exp_rd, "R7 rdata held", rdata, exp_rd);
        end
        io_wr = 1'b0; io_rd = 1'b0;
        @(negedge clk);
        check(grp_sel == 3'b000 && rd_claim == 1'b0, "R4 release", grp_sel, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=<100000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        check(hc_div_en == 1'b0, "R1 div reset", hc_div_en, 0);
        check(grp_sel == 3'b000, "R1 sel reset", grp_sel, 0);
        check(rd_claim == 1'b0, "R1 claim reset", rd_claim, 0);
        check(rdata == 8'hFF, "R1 rdata reset", rdata, 8'hFF);
        rst_n = 1'b1;
        rb_data = 24'hC3A55A;
        // directed corners
        access(10'h31A, 8'h00, 1, 0, 1);   // R6 set with zero data
        access(10'h31A, 8'h5A, 0, 1, 1);   // R11 read of strobe address
        access(10'h310, 8'h77, 1, 0, 1);   // R8 hole write
        access(10'h2FF, 8'h11, 1, 0, 1);   // R9 below window
        access(10'h31B, 8'h11, 0, 1, 1);   // R9 above window
        access(10'h319, 8'hFF, 1, 0, 5);   // R5 clear, held strobe R4
        access(10'h31A, 8'h33, 1, 1, 2);   // R10 both strobes
        access(10'h305, 8'h9C, 1, 0, 3);   // R2/R3 data port
        access(10'h30A, 8'h00, 0, 1, 4);   // R7 aux1 mask read
        access(10'h315, 8'h00, 0, 1, 1);   // R7 aux2 data read
        access(10'h313, 8'h42, 1, 1, 1);   // R10 at a group
        access(10'h300, 8'h00, 0, 1, 1);   // R8 hole read
        // random mix
        for (int n = 0; n < 400; n++) begin
            logic [9:0] a;
            int sel;
            a = 10'h2F8 + 10'($urandom_range(0, 39));
            sel = $urandom_range(0, 9);
            rb_data = 24'($urandom);
            access(a, 8'($urandom), sel < 5 || sel == 9, sel >= 5, $urandom_range(1, 4));
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule